// File: doc/BRIEF.md
# Eight-Bit ALU with Status-Flag Update and Branch Test

This block is the arithmetic core of a small 8-bit processor. It is purely combinational. It takes a left operand, a right operand (a register value or an immediate, whichever the caller selects), a carry input, a five-bit operation code and the current status byte. It returns the 8-bit result, a write-enable for that result, and the next status byte.

Each operation changes only its own fixed set of flags. Every other status bit, including the interrupt-enable bit and the user T bit, passes through unchanged. Subtract-with-carry and compare-with-carry can only clear the zero flag, never set it, so that a comparison of several bytes can be chained one byte at a time.

A separate condition evaluator reads the incoming status byte and answers a branch question. The question names one status bit and a polarity. The position of the sign bit is treated specially: there the evaluator uses N XOR V directly, which gives the signed greater-or-equal and less-than tests.

Top module: `alu8_core`

## Requirements
- R1: The status byte holds, from bit 7 down to bit 0: I, T, H, S, V, N, Z, C. No operation changes bits 7 and 6. Every operation that updates N or V also sets S to N XOR V. An updated N is bit 7 of the result. An updated Z is 1 exactly when the result is zero, except as R4 states.
- R2: ADD (code 0) and ADC (code 1) give the sum opA + opB, plus carryIn for ADC only, modulo 256. They update Z, C, N, V and H. C is the carry out of bit 7, H is the carry out of bit 3, and V is signed overflow.
- R3: SUB (code 2) and SBC (code 3) give opA − opB, minus carryIn for SBC only, modulo 256. They update Z, C, N, V and H. C is set on an unsigned borrow, H is the borrow from bit 4, and V is signed overflow.
- R4: For SBC (code 3) and CPC (code 5), a zero difference leaves Z at its incoming value and a nonzero difference clears Z. SUB and CP set Z from the zero test alone.
- R5: CP (code 4) and CPC (code 5) update the flags exactly as SUB and SBC do, and hold resultWe low. Every defined code other than these two drives resultWe high.
- R6: AND (code 6), OR (code 7) and XOR (code 8) update Z and N, clear V, and leave C and H unchanged.
- R7: INC (code 11) gives opA + 1 and DEC (code 12) gives opA − 1. Both update Z, N and V and leave C and H unchanged. V is set only when INC starts from 0x7F or DEC starts from 0x80.
- R8: COM (code 9) gives 0xFF − opA, sets C and clears V. NEG (code 10) gives 0x00 − opA and also updates H. For NEG, C is set when opA is nonzero, H is set when opA[3:0] is nonzero, and V is set only when opA is 0x80.
- R9: LSL (13) shifts in a zero at bit 0. LSR (14) shifts in a zero at bit 7. ROL (15) and ROR (16) move carryIn into the vacated end. ASR (17) keeps bit 7. In each case C receives the bit shifted out and V is set to N XOR C. These operations update Z, C, N and V and leave H unchanged.
- R10: SWAP (code 18) exchanges opA[7:4] with opA[3:0], and statusOut equals statusIn.
- R11: branchTaken is computed from statusIn. condCode[2:0] selects a status bit, and condCode[3] = 0 means the branch is taken when that bit is 1, while condCode[3] = 1 means it is taken when the bit is 0. When the selected position is 4, the evaluator tests N XOR V in place of the stored S bit, so code 4'b1100 is signed greater-or-equal and code 4'b0100 is signed less-than.
- R12: Codes 19 to 31 drive resultWe low, pass opA to result, and leave statusOut equal to statusIn.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 8 | Left operand (destination register value) |
| opB | input | 8 | Right operand (register value or immediate) |
| carryIn | input | 1 | Carry used by ADC, SBC, CPC, ROL and ROR |
| opCode | input | 5 | Operation code (R2 to R12) |
| statusIn | input | 8 | Current status byte |
| condCode | input | 4 | Branch condition: polarity bit and status-bit index |
| result | output | 8 | Operation result |
| resultWe | output | 1 | High when the result is to be written back |
| statusOut | output | 8 | Next status byte |
| branchTaken | output | 1 | Condition outcome over statusIn |

## Verification
Some properties are checked on every evaluation:
- the I and T bits pass through untouched;
- S equals N XOR V whenever N or V is updated;
- the chained zero flag never rises;
- an operation with no flag strobes leaves the status byte unchanged;
- the add carry and sum match the 9-bit sum;
- compares never write;
- SWAP exchanges nibbles;
- the signed greater-or-equal outcome agrees with N and V.

The exact flag values come only from the bench scenarios, which compare every output against a behavioural model. These values are the half-carry and borrow edges, overflow at 0x7F and 0x80, carry entering rotates, and the zero chain with Z both set and clear on entry.

// File: rtl/alu8_pkg.sv
`timescale 1ns/1ps
package alu8_pkg;
  localparam int DataW  = 8;
  localparam int MsbIdx = DataW - 1;
  localparam int NibW   = DataW / 2;
  localparam int OpW    = 5;
  localparam int CondW  = 4;

  // status bit positions
  localparam int FlagC = 0;
  localparam int FlagZ = 1;
  localparam int FlagN = 2;
  localparam int FlagV = 3;
  localparam int FlagS = 4;
  localparam int FlagH = 5;
  localparam int FlagT = 6;
  localparam int FlagI = 7;

  typedef enum logic [OpW-1:0] {
    OP_ADD  = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBC = 5'd3,
    OP_CP   = 5'd4,  OP_CPC = 5'd5,  OP_AND = 5'd6,  OP_OR  = 5'd7,
    OP_XOR  = 5'd8,  OP_COM = 5'd9,  OP_NEG = 5'd10, OP_INC = 5'd11,
    OP_DEC  = 5'd12, OP_LSL = 5'd13, OP_LSR = 5'd14, OP_ROL = 5'd15,
    OP_ROR  = 5'd16, OP_ASR = 5'd17, OP_SWAP = 5'd18
  } aluOp_e;

  typedef enum logic [2:0] {
    UNIT_PASS, UNIT_ARITH, UNIT_LOGIC, UNIT_SHIFT, UNIT_SWAP
  } unit_e;

  typedef enum logic [1:0] {LOGIC_AND, LOGIC_OR, LOGIC_XOR, LOGIC_NOT} logicFn_e;

  typedef enum logic [2:0] {SH_LSL, SH_LSR, SH_ROL, SH_ROR, SH_ASR} shiftFn_e;

  // strobes from control to datapath
  typedef struct packed {
    unit_e    unit;
    logic     subMode;
    logic     useCarry;
    logic     lhsZero;
    logic     rhsOne;
    logicFn_e logicFn;
    shiftFn_e shiftFn;
    logic     forceC;
    logic     updZ;
    logic     updC;
    logic     updN;
    logic     updV;
    logic     updH;
    logic     zChain;
  } aluCtrl_t;
endpackage

// File: rtl/alu8_ctrl.sv
`timescale 1ns/1ps
module alu8_ctrl
  import alu8_pkg::*;
(
  input  logic [OpW-1:0] opCode,
  output aluCtrl_t       ctrl,
  output logic           writeRes
);
  always_comb begin
    ctrl     = '0;
    writeRes = 1'b1;
    case (opCode)
      OP_ADD, OP_ADC: begin
        ctrl.unit     = UNIT_ARITH;
        ctrl.useCarry = (opCode == OP_ADC);
        {ctrl.updZ, ctrl.updC, ctrl.updN, ctrl.updV, ctrl.updH} = 5'b11111;
      end
      OP_SUB, OP_SBC, OP_CP, OP_CPC: begin
        ctrl.unit     = UNIT_ARITH;
        ctrl.subMode  = 1'b1;
        ctrl.useCarry = (opCode == OP_SBC) || (opCode == OP_CPC);
        ctrl.zChain   = ctrl.useCarry;
        {ctrl.updZ, ctrl.updC, ctrl.updN, ctrl.updV, ctrl.updH} = 5'b11111;
        writeRes      = (opCode == OP_SUB) || (opCode == OP_SBC);
      end
      OP_AND, OP_OR, OP_XOR: begin
        ctrl.unit    = UNIT_LOGIC;
        ctrl.logicFn = (opCode == OP_AND) ? LOGIC_AND :
                       (opCode == OP_OR)  ? LOGIC_OR  : LOGIC_XOR;
        {ctrl.updZ, ctrl.updN, ctrl.updV} = 3'b111;
      end
      OP_COM: begin
        ctrl.unit    = UNIT_LOGIC;
        ctrl.logicFn = LOGIC_NOT;
        ctrl.forceC  = 1'b1;
        {ctrl.updZ, ctrl.updC, ctrl.updN, ctrl.updV} = 4'b1111;
      end
      OP_NEG: begin
        ctrl.unit    = UNIT_ARITH;
        ctrl.subMode = 1'b1;
        ctrl.lhsZero = 1'b1;
        {ctrl.updZ, ctrl.updC, ctrl.updN, ctrl.updV, ctrl.updH} = 5'b11111;
      end
      OP_INC, OP_DEC: begin
        ctrl.unit    = UNIT_ARITH;
        ctrl.subMode = (opCode == OP_DEC);
        ctrl.rhsOne  = 1'b1;
        {ctrl.updZ, ctrl.updN, ctrl.updV} = 3'b111;
      end
      OP_LSL, OP_LSR, OP_ROL, OP_ROR, OP_ASR: begin
        ctrl.unit    = UNIT_SHIFT;
        ctrl.shiftFn = (opCode == OP_LSL) ? SH_LSL :
                       (opCode == OP_LSR) ? SH_LSR :
                       (opCode == OP_ROL) ? SH_ROL :
                       (opCode == OP_ROR) ? SH_ROR : SH_ASR;
        {ctrl.updZ, ctrl.updC, ctrl.updN, ctrl.updV} = 4'b1111;
      end
      OP_SWAP: ctrl.unit = UNIT_SWAP;
      default: writeRes = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu8_datapath.sv
`timescale 1ns/1ps
module alu8_datapath
  import alu8_pkg::*;
(
  input  aluCtrl_t         ctrl,
  input  logic [DataW-1:0] opA,
  input  logic [DataW-1:0] opB,
  input  logic             carryIn,
  input  logic [DataW-1:0] statusIn,
  output logic [DataW-1:0] result,
  output logic [DataW-1:0] statusOut
);
  logic [DataW-1:0] lhs, rhs;
  logic             cinEff;
  logic [DataW:0]   wide;
  logic             arithC, arithV, arithH;
  logic [DataW-1:0] logicRes, shiftRes, swapRes;
  logic             shiftC;
  logic             newC, newV, isZero;

  // operand steering
  always_comb begin
    lhs    = ctrl.lhsZero ? '0 : opA;
    rhs    = ctrl.lhsZero ? opA : (ctrl.rhsOne ? DataW'(1) : opB);
    cinEff = ctrl.useCarry & carryIn;
  end

  // adder / subtractor
  always_comb begin
    if (ctrl.subMode) begin
      wide   = {1'b0, lhs} - {1'b0, rhs} - (DataW+1)'(cinEff);
      arithV = (lhs[MsbIdx] ^ rhs[MsbIdx]) & (lhs[MsbIdx] ^ wide[MsbIdx]);
      arithH = (~lhs[NibW-1] & rhs[NibW-1]) | (rhs[NibW-1] & wide[NibW-1]) |
               (wide[NibW-1] & ~lhs[NibW-1]);
    end else begin
      wide   = {1'b0, lhs} + {1'b0, rhs} + (DataW+1)'(cinEff);
      arithV = ~(lhs[MsbIdx] ^ rhs[MsbIdx]) & (lhs[MsbIdx] ^ wide[MsbIdx]);
      arithH = (lhs[NibW-1] & rhs[NibW-1]) | (rhs[NibW-1] & ~wide[NibW-1]) |
               (~wide[NibW-1] & lhs[NibW-1]);
    end
    arithC = wide[DataW];
  end

  // logic unit
  always_comb begin
    case (ctrl.logicFn)
      LOGIC_AND: logicRes = opA & opB;
      LOGIC_OR:  logicRes = opA | opB;
      LOGIC_XOR: logicRes = opA ^ opB;
      default:   logicRes = ~opA;
    endcase
  end

  // shifter
  always_comb begin
    case (ctrl.shiftFn)
      SH_LSL: begin shiftRes = {opA[MsbIdx-1:0], 1'b0};    shiftC = opA[MsbIdx]; end
      SH_LSR: begin shiftRes = {1'b0, opA[MsbIdx:1]};      shiftC = opA[0];      end
      SH_ROL: begin shiftRes = {opA[MsbIdx-1:0], carryIn}; shiftC = opA[MsbIdx]; end
      SH_ROR: begin shiftRes = {carryIn, opA[MsbIdx:1]};   shiftC = opA[0];      end
      default: begin shiftRes = {opA[MsbIdx], opA[MsbIdx:1]}; shiftC = opA[0];   end
    endcase
  end

  assign swapRes = {opA[NibW-1:0], opA[DataW-1:NibW]};

  // result and raw flag select
  always_comb begin
    case (ctrl.unit)
      UNIT_ARITH: begin result = wide[DataW-1:0]; newC = arithC;      newV = arithV; end
      UNIT_LOGIC: begin result = logicRes;        newC = ctrl.forceC; newV = 1'b0;   end
      UNIT_SHIFT: begin result = shiftRes;        newC = shiftC;
                        newV = shiftRes[MsbIdx] ^ shiftC; end
      UNIT_SWAP:  begin result = swapRes;         newC = 1'b0;        newV = 1'b0;   end
      default:    begin result = opA;             newC = 1'b0;        newV = 1'b0;   end
    endcase
    isZero = (result == '0);
  end

  // flag merge
  always_comb begin
    statusOut = statusIn;
    if (ctrl.updC) statusOut[FlagC] = newC;
    if (ctrl.updH) statusOut[FlagH] = arithH;
    if (ctrl.updV) statusOut[FlagV] = newV;
    if (ctrl.updN) statusOut[FlagN] = result[MsbIdx];
    if (ctrl.updZ) statusOut[FlagZ] = ctrl.zChain ? (isZero & statusIn[FlagZ]) : isZero;
    if (ctrl.updN | ctrl.updV)
      statusOut[FlagS] = statusOut[FlagN] ^ statusOut[FlagV];
  end

  always_comb begin
    if (!$isunknown({ctrl, opA, opB, carryIn, statusIn})) begin
      // R1
      it_keep_chk: assert (statusOut[FlagI:FlagT] == statusIn[FlagI:FlagT])
        else $error("I/T bits altered");
      // R1
      sign_rule_chk: assert (!(ctrl.updN | ctrl.updV) ||
                             statusOut[FlagS] == (statusOut[FlagN] ^ statusOut[FlagV]))
        else $error("S differs from N^V");
      // R4
      zchain_chk: assert (!(ctrl.zChain && !statusIn[FlagZ]) || !statusOut[FlagZ])
        else $error("chained Z rose");
      // R10
      noflag_keep_chk: assert ((ctrl.updZ | ctrl.updC | ctrl.updN | ctrl.updV | ctrl.updH) ||
                               statusOut == statusIn)
        else $error("status changed without strobes");
    end
  end
endmodule

// File: rtl/alu8_branch.sv
`timescale 1ns/1ps
module alu8_branch
  import alu8_pkg::*;
(
  input  logic [DataW-1:0] statusIn,
  input  logic [CondW-1:0] condCode,
  output logic             taken
);
  logic [CondW-2:0] sel;
  logic             bitVal;

  always_comb begin
    sel    = condCode[CondW-2:0];
    bitVal = (sel == (CondW-1)'(FlagS)) ? (statusIn[FlagN] ^ statusIn[FlagV])
                                        : statusIn[sel];
    taken  = bitVal ^ condCode[CondW-1];
  end

  always_comb begin
    if (!$isunknown({statusIn, condCode})) begin
      // R11
      signed_ge_chk: assert (condCode != 4'b1100 ||
                             taken == (statusIn[FlagN] == statusIn[FlagV]))
        else $error("signed GE wrong");
    end
  end
endmodule

// File: rtl/alu8_core.sv
`timescale 1ns/1ps
module alu8_core
  import alu8_pkg::*;
(
  input  logic [7:0] opA,
  input  logic [7:0] opB,
  input  logic       carryIn,
  input  logic [4:0] opCode,
  input  logic [7:0] statusIn,
  input  logic [3:0] condCode,
  output logic [7:0] result,
  output logic       resultWe,
  output logic [7:0] statusOut,
  output logic       branchTaken
);
  aluCtrl_t ctrl;

  alu8_ctrl u_ctrl (
    .opCode  (opCode),
    .ctrl    (ctrl),
    .writeRes(resultWe)
  );

  alu8_datapath u_dp (
    .ctrl     (ctrl),
    .opA      (opA),
    .opB      (opB),
    .carryIn  (carryIn),
    .statusIn (statusIn),
    .result   (result),
    .statusOut(statusOut)
  );

  alu8_branch u_br (
    .statusIn(statusIn),
    .condCode(condCode),
    .taken   (branchTaken)
  );

  always_comb begin
    if (!$isunknown({opA, opB, opCode, carryIn, statusIn})) begin
      // R2
      add_sum_chk: assert (opCode != OP_ADD ||
                           {statusOut[FlagC], result} == ({1'b0, opA} + {1'b0, opB}))
        else $error("ADD sum/carry wrong");
      // R5
      compare_nowrite_chk: assert (!(opCode == OP_CP || opCode == OP_CPC) || !resultWe)
        else $error("compare wrote result");
      // R10
      swap_nibble_chk: assert (opCode != OP_SWAP || result == {opA[3:0], opA[7:4]})
        else $error("SWAP wrong");
    end
  end
endmodule

// File: tb/alu8_core_tb.sv
`timescale 1ns/1ps
module alu8_core_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic active = 1'b0;
  logic done = 1'b0;
  int   checks = 0;
  int   errors = 0;

  logic [7:0] opA = '0, opB = '0, statusIn = '0;
  logic       carryIn = 1'b0;
  logic [4:0] opCode = '0;
  logic [3:0] condCode = '0;
  logic [7:0] result, statusOut;
  logic       resultWe, branchTaken;

  always #10 clk = ~clk;  // 50 MHz

  alu8_core dut_i (
    .opA(opA), .opB(opB), .carryIn(carryIn), .opCode(opCode),
    .statusIn(statusIn), .condCode(condCode), .result(result),
    .resultWe(resultWe), .statusOut(statusOut), .branchTaken(branchTaken)
  );

  // behavioural model: returns {we, result, status}
  function automatic logic [16:0] model(int op, int a, int b, int cin, logic [7:0] st);
    int r = a; int s; bit c = st[0], h = st[5], v = st[3];
    bit uz = 0, uc = 0, un = 0, uv = 0, uh = 0, chain = 0, we = 1;
    logic [7:0] o = st;
    case (op)
      0, 1: begin
        int ce = (op == 1) ? cin : 0;
        s = a + b + ce; r = s & 255; c = s > 255;
        h = ((a & 15) + (b & 15) + ce) > 15;
        v = ((a ^ r) & (b ^ r) & 128) != 0;
        {uz, uc, un, uv, uh} = 5'b11111;
      end
      2, 3, 4, 5: begin
        int ce = (op == 3 || op == 5) ? cin : 0;
        s = a - b - ce; r = s & 255; c = s < 0;
        h = ((a & 15) - (b & 15) - ce) < 0;
        v = ((a ^ b) & (a ^ r) & 128) != 0;
        {uz, uc, un, uv, uh} = 5'b11111;
        chain = (op == 3 || op == 5);
        we = (op == 2 || op == 3);
      end
      6, 7, 8: begin
        r = (op == 6) ? (a & b) : (op == 7) ? (a | b) : (a ^ b);
        v = 0; {uz, un, uv} = 3'b111;
      end
      9:  begin r = 255 - a; c = 1; v = 0; {uz, uc, un, uv} = 4'b1111; end
      10: begin r = (256 - a) & 255; c = a != 0; h = (a & 15) != 0; v = a == 128;
                {uz, uc, un, uv, uh} = 5'b11111; end
      11: begin r = (a + 1) & 255; v = a == 127; {uz, un, uv} = 3'b111; end
      12: begin r = (a + 255) & 255; v = a == 128; {uz, un, uv} = 3'b111; end
      13, 14, 15, 16, 17: begin
        if (op == 13)      begin r = (a * 2) & 255;             c = (a >> 7) & 1; end
        else if (op == 14) begin r = a / 2;                     c = a & 1; end
        else if (op == 15) begin r = ((a * 2) & 255) + cin;     c = (a >> 7) & 1; end
        else if (op == 16) begin r = cin * 128 + a / 2;         c = a & 1; end
        else               begin r = (a & 128) + a / 2;         c = a & 1; end
        v = ((r >> 7) & 1) != c;
        {uz, uc, un, uv} = 4'b1111;
      end
      18: r = ((a & 15) * 16) + (a / 16);
      default: we = 0;
    endcase
    if (uc) o[0] = c;
    if (uh) o[5] = h;
    if (uv) o[3] = v;
    if (un) o[2] = (r >> 7) & 1;
    if (uz) o[1] = chain ? ((r == 0) && st[1]) : (r == 0);
    if (un || uv) o[4] = o[2] ^ o[3];
    return {we, 8'(r), o};
  endfunction

  function automatic string tagOf(int op);
    case (op)
      0, 1: return "R2";
      2, 3: return "R3";
      4, 5: return "R5";
      6, 7, 8: return "R6";
      9, 10: return "R8";
      11, 12: return "R7";
      13, 14, 15, 16, 17: return "R9";
      18: return "R10";
      default: return "R12";
    endcase
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h (op=%0d a=%0h b=%0h cin=%0d st=%0h cc=%0h)",
               tag, what, act, exp, opCode, opA, opB, carryIn, statusIn, condCode);
    end
  endtask

  // compare against the model on every clock
  always @(posedge clk) begin
    if (active) begin
      logic [16:0] e;
      int idx; bit bv, tk;
      e = model(int'(opCode), int'(opA), int'(opB), int'(carryIn), statusIn);
      chk(result == e[15:8], tagOf(opCode), "result", result, e[15:8]);
      chk(statusOut == e[7:0], tagOf(opCode), "status", statusOut, e[7:0]);
      chk(resultWe == e[16], (opCode == 4 || opCode == 5) ? "R5" : tagOf(opCode),
          "resultWe", resultWe, e[16]);
      chk(statusOut[7:6] == statusIn[7:6], "R1", "I/T", statusOut[7:6], statusIn[7:6]);
      if (opCode >= 2 && opCode <= 5)
        chk(statusOut[1] == e[1], "R4", "Z", statusOut[1], e[1]);
      idx = int'(condCode[2:0]);
      bv  = (idx == 4) ? (statusIn[2] ^ statusIn[3]) : statusIn[idx];
      tk  = condCode[3] ? !bv : bv;
      chk(branchTaken == tk, "R11", "branch", branchTaken, tk);
    end
  end

  task automatic drv(int op, int a, int b, int cin, int st, int cc);
    @(negedge clk);
    opCode = 5'(op); opA = 8'(a); opB = 8'(b);
    carryIn = 1'(cin); statusIn = 8'(st); condCode = 4'(cc);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    @(negedge clk);
    active = 1'b1;                       // reset-state vector: all zero inputs
    drv(0, 8'h7F, 8'h01, 0, 8'h00, 4'hC); // R2 V,H
    drv(0, 8'hFF, 8'h01, 0, 8'hC0, 4'h1); // R2 C,Z,H
    drv(1, 8'h0F, 8'h00, 1, 8'h00, 4'h0); // R2 carry-in
    drv(1, 8'h0F, 8'h00, 0, 8'h01, 4'h8);
    drv(2, 8'h00, 8'h01, 0, 8'h00, 4'h4); // R3 borrow
    drv(2, 8'h80, 8'h01, 0, 8'h00, 4'hC); // R3 V
    drv(3, 8'h10, 8'h10, 0, 8'h00, 4'h1); // R4 zero, Z in 0
    drv(3, 8'h10, 8'h10, 0, 8'h02, 4'h1); // R4 zero, Z in 1
    drv(5, 8'h01, 8'h00, 1, 8'h02, 4'h9); // R4/R5 chain
    drv(5, 8'h05, 8'h03, 1, 8'h02, 4'h9); // R4 nonzero clears Z
    drv(4, 8'h33, 8'h33, 0, 8'h00, 4'h1); // R5 compare
    drv(6, 8'hF0, 8'h0F, 0, 8'h29, 4'h0); // R6 AND keeps C,H
    drv(7, 8'h80, 8'h01, 0, 8'h08, 4'h2); // R6 OR clears V
    drv(8, 8'hAA, 8'hAA, 0, 8'h21, 4'h1); // R6 XOR zero
    drv(9, 8'h00, 8'h00, 0, 8'h00, 4'h0); // R8 COM
    drv(10, 8'h80, 8'h00, 0, 8'h00, 4'h3);// R8 NEG V
    drv(10, 8'h00, 8'h00, 0, 8'h3F, 4'h0);// R8 NEG zero
    drv(10, 8'h10, 8'h00, 0, 8'h00, 4'h5);// R8 NEG H clear
    drv(11, 8'h7F, 8'h00, 0, 8'h21, 4'hC);// R7 INC V
    drv(11, 8'hFF, 8'h00, 0, 8'h00, 4'h1);// R7 INC wrap keeps C
    drv(12, 8'h80, 8'h00, 0, 8'h00, 4'h4);// R7 DEC V
    drv(12, 8'h01, 8'h00, 0, 8'h21, 4'h1);// R7 DEC zero
    drv(13, 8'h81, 8'h00, 1, 8'h20, 4'h0);// R9 LSL
    drv(14, 8'h01, 8'h00, 1, 8'h00, 4'h0);// R9 LSR
    drv(15, 8'h80, 8'h00, 1, 8'h00, 4'h0);// R9 ROL carry in
    drv(16, 8'h01, 8'h00, 1, 8'h00, 4'h0);// R9 ROR carry in
    drv(17, 8'h81, 8'h00, 0, 8'h00, 4'h0);// R9 ASR keeps bit 7
    drv(18, 8'h3C, 8'h00, 0, 8'hFF, 4'h7);// R10 SWAP
    drv(18, 8'hA5, 8'h00, 0, 8'h00, 4'hF);
    drv(19, 8'h5A, 8'hFF, 1, 8'hA5, 4'h4);// R12 undefined
    drv(31, 8'h00, 8'h00, 0, 8'h00, 4'hC);
    for (int cc = 0; cc < 16; cc++) begin // R11 every condition
      drv(18, 8'h00, 8'h00, 0, 8'h08, cc);
      drv(18, 8'h00, 8'h00, 0, 8'h14, cc);
      drv(18, 8'h00, 8'h00, 0, 8'h0C, cc);
    end
    for (int i = 0; i < 4000; i++)
      drv($urandom_range(0, 31), $urandom_range(0, 255), $urandom_range(0, 255),
          $urandom_range(0, 1), $urandom_range(0, 255), $urandom_range(0, 15));
    @(posedge clk);
    @(negedge clk);
    active = 1'b0;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule